// File: doc/BRIEF.md
# Test-Port Instruction and Pin-Control Logic

This block is the instruction-dependent half of an IEEE 1149.1 test access port. An external TAP state machine gives it one-cycle capture, shift and update strobes for the instruction and data paths, plus a Test-Logic-Reset flag. The block holds the instruction register and decodes it. It chooses which serial register connects TDI to TDO: a 1-bit bypass stage, a 32-bit identification register or a boundary-scan register. It also chooses the source of the pad outputs, which is the core, the boundary-scan update latch, or tri-state.

The block keeps two 32-bit user codes. The active code belongs to the running design and is the only one the serial port reports. The pending code is written by an in-system update. It reaches the active copy only on a reload strobe, which stands for a power-up or a forced reload. Under the user-code instruction the block reports all ones until configuration is finished. The per-pin weak pull-up and bus-hold enables pass through to the pads under every instruction.

Top module: `tap_insn_ctrl`

## Requirements
- R1: After reset, or in any cycle where `tlr` is high, the instruction becomes IDCODE (opcode 10'h006). Pads then follow `core_oe` and `core_do`.
- R2: Capture-IR loads 10'b0000000001. Serial registers shift toward TDO least significant bit first, with `tdi` entering at the top. Update-IR makes the shifted value the instruction. The opcodes are BYPASS 10'h3FF, IDCODE 10'h006, USERCODE 10'h007, SAMPLE 10'h005, EXTEST 10'h000, CLAMP 10'h00A and HIGHZ 10'h00B. Any other opcode acts as BYPASS.
- R3: Under IDCODE, Capture-DR loads the `ID_VALUE` parameter into the 32-bit identification register.
- R4: Under USERCODE, the identification register is the serial path. Capture-DR loads the active user code when `cfg_done` is high, and 32'hFFFFFFFF when it is low.
- R5: A pulse on `isp_wr` stores `isp_code` as the pending code only. A later USERCODE capture still returns the previous active code.
- R6: A pulse on `reload` copies the pending code into the active code. Both codes reset to `UCODE_INIT`.
- R7: Under BYPASS, CLAMP, HIGHZ and unknown opcodes, the path is a 1-bit stage that captures 0. TDO is therefore TDI delayed by one shift.
- R8: Under CLAMP, `pad_oe` equals update-latch bits [2N-1:N] and `pad_do` equals bits [N-1:0].
- R9: Under HIGHZ, every bit of `pad_oe` is 0, whatever the core drives, until another instruction is loaded.
- R10: `pad_pu` equals `keep_pu` and `pad_bh` equals `keep_bh` under every instruction.
- R11: `tdo` and `tdo_en` change only on the falling edge of `tck`. `tdo_en` is high only in the falling edges during Shift-IR or Shift-DR.
- R12: Under SAMPLE or EXTEST, the 2N-bit boundary register is the serial path. Capture-DR loads `{core_oe, pad_di}`, and Update-DR copies the register into the update latch. SAMPLE leaves the pads on the core. EXTEST drives them from the latch, in the same way as R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tlr | input | 1 | TAP is in Test-Logic-Reset |
| capture_ir | input | 1 | Capture-IR strobe |
| shift_ir | input | 1 | Shift-IR strobe |
| update_ir | input | 1 | Update-IR strobe |
| capture_dr | input | 1 | Capture-DR strobe |
| shift_dr | input | 1 | Shift-DR strobe |
| update_dr | input | 1 | Update-DR strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, falling-edge timed |
| tdo_en | output | 1 | TDO driver enable |
| cfg_done | input | 1 | Configuration finished |
| isp_wr | input | 1 | Write a pending user code |
| isp_code | input | 32 | Pending user code value |
| reload | input | 1 | Copy pending code to active code |
| core_oe | input | NPINS | Core output enables |
| core_do | input | NPINS | Core output data |
| pad_di | input | NPINS | Pad input levels |
| keep_pu | input | NPINS | Weak pull-up enables |
| keep_bh | input | NPINS | Bus-hold enables |
| pad_oe | output | NPINS | Pad output enables |
| pad_do | output | NPINS | Pad output data |
| pad_pu | output | NPINS | Pad weak pull-up enables |
| pad_bh | output | NPINS | Pad bus-hold enables |

## Verification
The identification path is read under USERCODE three times. The first read is before configuration completes and must give all ones. The second follows an in-system write and must still give the old code. The third follows a reload and must give the new code. Together these separate the active copy from the pending copy. Bypass-path shifts use both an unknown opcode and the pin-holding instructions, with non-repeating bit patterns, so a missing zero capture or a wrong path length shows up as a shifted word. The boundary path is preloaded with one pattern while the core drives a different one. The same preloaded values must appear at the pads under EXTEST and CLAMP and not under SAMPLE. Under HIGHZ, the core enables are changed while the pads are watched.

// File: rtl/tap_insn_ctrl.sv
module tap_insn_ctrl #(
  parameter int          NPINS      = 8,
  parameter int          IRW        = 10,
  parameter logic [31:0] ID_VALUE   = 32'h1A5C_30DD,
  parameter logic [31:0] UCODE_INIT = 32'hC0DE_0001
) (
  input  logic             tck,
  input  logic             rst_n,
  input  logic             tlr,
  input  logic             capture_ir,
  input  logic             shift_ir,
  input  logic             update_ir,
  input  logic             capture_dr,
  input  logic             shift_dr,
  input  logic             update_dr,
  input  logic             tdi,
  output logic             tdo,
  output logic             tdo_en,
  input  logic             cfg_done,
  input  logic             isp_wr,
  input  logic [31:0]      isp_code,
  input  logic             reload,
  input  logic [NPINS-1:0] core_oe,
  input  logic [NPINS-1:0] core_do,
  input  logic [NPINS-1:0] pad_di,
  input  logic [NPINS-1:0] keep_pu,
  input  logic [NPINS-1:0] keep_bh,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_do,
  output logic [NPINS-1:0] pad_pu,
  output logic [NPINS-1:0] pad_bh
);
  localparam int BSW = 2 * NPINS;
  localparam logic [IRW-1:0] OP_EXTEST = IRW'(0);
  localparam logic [IRW-1:0] OP_SAMPLE = IRW'(5);
  localparam logic [IRW-1:0] OP_IDCODE = IRW'(6);
  localparam logic [IRW-1:0] OP_USER   = IRW'(7);
  localparam logic [IRW-1:0] OP_CLAMP  = IRW'(10);
  localparam logic [IRW-1:0] OP_HIGHZ  = IRW'(11);

  logic [IRW-1:0] ir_sr, ir;
  logic           byp;
  logic [31:0]    id_sr, pending, active;
  logic [BSW-1:0] bsr, upd;

  logic is_id, is_uc, is_bs, sel_id, drive_bs, hiz;
  assign is_id    = (ir == OP_IDCODE);
  assign is_uc    = (ir == OP_USER);
  assign is_bs    = (ir == OP_SAMPLE) || (ir == OP_EXTEST);
  assign sel_id   = is_id || is_uc;
  assign drive_bs = (ir == OP_EXTEST) || (ir == OP_CLAMP);
  assign hiz      = (ir == OP_HIGHZ);

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      ir_sr   <= '0;
      ir      <= OP_IDCODE;
      byp     <= 1'b0;
      id_sr   <= '0;
      bsr     <= '0;
      upd     <= '0;
      pending <= UCODE_INIT;
      active  <= UCODE_INIT;
    end else begin
      if (tlr)            ir <= OP_IDCODE;
      else if (update_ir) ir <= ir_sr;

      if (capture_ir)    ir_sr <= IRW'(1);
      else if (shift_ir) ir_sr <= {tdi, ir_sr[IRW-1:1]};

      if (capture_dr) begin
        byp <= 1'b0;
        if (sel_id) id_sr <= is_uc ? (cfg_done ? active : '1) : ID_VALUE;
        if (is_bs)  bsr   <= {core_oe, pad_di};
      end else if (shift_dr) begin
        if (sel_id)     id_sr <= {tdi, id_sr[31:1]};
        else if (is_bs) bsr   <= {tdi, bsr[BSW-1:1]};
        else            byp   <= tdi;
      end

      if (update_dr && is_bs) upd <= bsr;

      if (reload) active  <= pending;
      if (isp_wr) pending <= isp_code;
    end
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= shift_ir || shift_dr;
      tdo    <= shift_ir ? ir_sr[0] : sel_id ? id_sr[0] : is_bs ? bsr[0] : byp;
    end
  end

  assign pad_oe = hiz ? '0 : drive_bs ? upd[BSW-1:NPINS] : core_oe;
  assign pad_do = drive_bs ? upd[NPINS-1:0] : core_do;
  assign pad_pu = keep_pu;
  assign pad_bh = keep_bh;
endmodule

module tap_insn_chk #(
  parameter int NPINS = 8,
  parameter int IRW   = 10
) (
  input logic             tck,
  input logic             rst_n,
  input logic             tlr,
  input logic             capture_dr,
  input logic             shift_ir,
  input logic             shift_dr,
  input logic             tdo_en,
  input logic             cfg_done,
  input logic             isp_wr,
  input logic             reload,
  input logic [IRW-1:0]   ir,
  input logic [31:0]      id_sr,
  input logic [31:0]      active,
  input logic             byp,
  input logic [NPINS-1:0] pad_oe
);
  localparam logic [IRW-1:0] C_IDCODE = IRW'(6);
  localparam logic [IRW-1:0] C_USER   = IRW'(7);
  localparam logic [IRW-1:0] C_HIGHZ  = IRW'(11);

  // R1
  tlr_idcode_chk: assert property (@(posedge tck) disable iff (!rst_n)
    tlr |=> ir == C_IDCODE);
  // R4
  ucode_valid_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (capture_dr && ir == C_USER && cfg_done) |=> id_sr == $past(active));
  // R4
  ucode_unconf_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (capture_dr && ir == C_USER && !cfg_done) |=> id_sr == 32'hFFFF_FFFF);
  // R5
  pending_only_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (isp_wr && !reload) |=> $stable(active));
  // R7
  byp_zero_chk: assert property (@(posedge tck) disable iff (!rst_n)
    capture_dr |=> !byp);
  // R9
  highz_oe_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (ir == C_HIGHZ) |-> pad_oe == '0);
  // R11
  tdo_en_chk: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_en |-> (shift_ir || shift_dr));
endmodule

bind tap_insn_ctrl tap_insn_chk #(.NPINS(NPINS), .IRW(IRW)) u_chk (
  .tck(tck), .rst_n(rst_n), .tlr(tlr), .capture_dr(capture_dr),
  .shift_ir(shift_ir), .shift_dr(shift_dr), .tdo_en(tdo_en),
  .cfg_done(cfg_done), .isp_wr(isp_wr), .reload(reload), .ir(ir),
  .id_sr(id_sr), .active(active), .byp(byp), .pad_oe(pad_oe)
);

// File: tb/sim_tap_insn_ctrl.sv
module sim_tap_insn_ctrl;
  localparam int N = 8;
  localparam int IRW = 10;
  localparam logic [31:0] IDV = 32'h1A5C_30DD;
  localparam logic [31:0] UINIT = 32'hC0DE_0001;
  localparam int OPB = 'h3FF, OPID = 'h006, OPUC = 'h007, OPSA = 'h005,
                 OPEX = 'h000, OPCL = 'h00A, OPHZ = 'h00B;
  localparam logic [5:0] S_IDLE = 6'b000000, S_CI = 6'b100000, S_SI = 6'b010000,
                         S_UI = 6'b001000, S_CD = 6'b000100, S_SD = 6'b000010,
                         S_UD = 6'b000001;

  logic tck = 0, rst_n = 0, tlr = 0;
  logic capture_ir = 0, shift_ir = 0, update_ir = 0, capture_dr = 0, shift_dr = 0, update_dr = 0;
  logic tdi = 0, tdo, tdo_en, cfg_done = 0, isp_wr = 0, reload = 0;
  logic [31:0] isp_code = 0;
  logic [N-1:0] core_oe = 0, core_do = 0, pad_di = 0, keep_pu = 0, keep_bh = 0;
  logic [N-1:0] pad_oe, pad_do, pad_pu, pad_bh;

  int errors = 0, checks = 0;

  always #5 tck = ~tck;

  tap_insn_ctrl #(.NPINS(N), .IRW(IRW), .ID_VALUE(IDV), .UCODE_INIT(UINIT)) u0 (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_ir;
  bit q_ir[$];
  bit q_dr[$];
  bit [2*N-1:0] m_upd;
  bit [31:0] m_act, m_pend;

  function automatic bit m_bs(int op); return op == OPSA || op == OPEX; endfunction

  always @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      m_ir = OPID; q_ir = {}; q_dr = {}; m_upd = '0; m_act = UINIT; m_pend = UINIT;
    end else begin
      bit [31:0] old_pend;
      old_pend = m_pend;
      if (capture_dr) begin
        q_dr = {};
        if (m_ir == OPID)      for (int i = 0; i < 32; i++) q_dr.push_back(IDV[i]);
        else if (m_ir == OPUC) for (int i = 0; i < 32; i++) q_dr.push_back(cfg_done ? m_act[i] : 1'b1);
        else if (m_bs(m_ir)) begin
          for (int i = 0; i < N; i++) q_dr.push_back(pad_di[i]);
          for (int i = 0; i < N; i++) q_dr.push_back(core_oe[i]);
        end else q_dr.push_back(1'b0);
      end else if (shift_dr && q_dr.size() > 0) begin
        void'(q_dr.pop_front()); q_dr.push_back(tdi);
      end
      if (update_dr && m_bs(m_ir) && q_dr.size() == 2*N)
        for (int i = 0; i < 2*N; i++) m_upd[i] = q_dr[i];
      if (capture_ir) begin
        q_ir = {}; q_ir.push_back(1'b1);
        for (int i = 1; i < IRW; i++) q_ir.push_back(1'b0);
      end else if (shift_ir && q_ir.size() > 0) begin
        void'(q_ir.pop_front()); q_ir.push_back(tdi);
      end
      if (tlr) m_ir = OPID;
      else if (update_ir && q_ir.size() == IRW) begin
        m_ir = 0;
        for (int i = 0; i < IRW; i++) m_ir = m_ir | (int'(q_ir[i]) << i);
      end
      if (reload) m_act = old_pend;
      if (isp_wr) m_pend = isp_code;
    end
  end

  // every-cycle comparison, after the falling edge
  logic last_tdo;
  bit last_ok = 0;
  always @(posedge tck) begin
    #2;
    // R11 tdo holds across the rising edge
    if (rst_n && last_ok) chk("R11 tdo stable at rise", tdo, last_tdo);
    #7;
    if (rst_n) begin
      logic [N-1:0] e_oe, e_do;
      string tg;
      if (m_ir == OPHZ) begin e_oe = '0; e_do = core_do; tg = "R9 pins"; end
      else if (m_ir == OPEX || m_ir == OPCL) begin
        e_oe = m_upd[2*N-1:N]; e_do = m_upd[N-1:0]; tg = (m_ir == OPCL) ? "R8 pins" : "R12 pins";
      end else begin e_oe = core_oe; e_do = core_do; tg = "R1 pins"; end
      chk(tg, {pad_oe, pad_do}, {e_oe, e_do});
      chk("R10 keepers", {pad_pu, pad_bh}, {keep_pu, keep_bh});
      chk("R11 tdo_en", tdo_en, shift_ir || shift_dr);
      if (shift_ir && q_ir.size() > 0) chk("R2 tdo ir", tdo, q_ir[0]);
      else if (shift_dr && q_dr.size() > 0) chk("R11 tdo dr", tdo, q_dr[0]);
      last_tdo = tdo; last_ok = 1;
    end
  end

  task automatic step(input logic [5:0] s, input logic d, output logic o);
    @(posedge tck); #1;
    {capture_ir, shift_ir, update_ir, capture_dr, shift_dr, update_dr} = s;
    tdi = d;
    #8; o = tdo;
  endtask

  task automatic run_ir(input int op, output logic [IRW-1:0] out);
    logic o;
    step(S_CI, 0, o);
    for (int i = 0; i < IRW; i++) begin step(S_SI, op[i], o); out[i] = o; end
    step(S_UI, 0, o);
    step(S_IDLE, 0, o);
  endtask

  task automatic run_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
    logic o;
    dout = '0;
    step(S_CD, 0, o);
    for (int i = 0; i < n; i++) begin step(S_SD, din[i], o); dout[i] = o; end
    step(S_UD, 0, o);
    step(S_IDLE, 0, o);
  endtask

  task automatic set_in(input logic [N-1:0] oe, input logic [N-1:0] d, input logic [N-1:0] di,
                        input logic [N-1:0] pu, input logic [N-1:0] bh, input logic cd);
    @(posedge tck); #1;
    {capture_ir, shift_ir, update_ir, capture_dr, shift_dr, update_dr} = S_IDLE;
    core_oe = oe; core_do = d; pad_di = di; keep_pu = pu; keep_bh = bh; cfg_done = cd;
  endtask

  task automatic pulse(input int which, input logic [31:0] code);
    @(posedge tck); #1;
    if (which == 0) begin isp_wr = 1; isp_code = code; end
    else if (which == 1) reload = 1;
    else tlr = 1;
    @(posedge tck); #1;
    isp_wr = 0; reload = 0; tlr = 0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [IRW-1:0] irout;
    logic [63:0] d;
    repeat (3) @(posedge tck);
    #1 rst_n = 1;
    set_in(8'h3C, 8'h96, 8'h00, 8'h0F, 8'hF0, 0);
    @(posedge tck); #9;
    chk("R1 reset pins", {pad_oe, pad_do}, {8'h3C, 8'h96});
    chk("R11 reset tdo_en", tdo_en, 0);

    run_dr(32, 0, d);
    chk("R3 idcode after reset (R1)", d[31:0], IDV);

    run_ir(OPUC, irout);
    chk("R2 ir capture pattern", irout, 10'b0000000001);
    run_dr(32, 0, d);
    chk("R4 usercode unconfigured", d[31:0], 32'hFFFF_FFFF);
    set_in(8'h3C, 8'h96, 8'h00, 8'hA1, 8'h1A, 1);
    run_dr(32, 0, d);
    chk("R4 usercode configured", d[31:0], UINIT);
    pulse(0, 32'h1234_5678);
    run_dr(32, 0, d);
    chk("R5 pending not reported", d[31:0], UINIT);
    pulse(1, 0);
    run_dr(32, 0, d);
    chk("R6 reloaded code", d[31:0], 32'h1234_5678);

    run_ir('h155, irout);
    run_dr(8, 64'hB4, d);
    chk("R2 unknown opcode bypass (R7)", d[7:0], 8'h68);
    run_ir(OPB, irout);
    run_dr(8, 64'h4D, d);
    chk("R7 bypass delay", d[7:0], 8'h9A);

    set_in(8'hA5, 8'h0F, 8'h3C, 8'h55, 8'hAA, 1);
    run_ir(OPSA, irout);
    run_dr(16, 64'h5AC3, d);
    chk("R12 sample capture", d[15:0], 16'hA53C);
    @(posedge tck); #9;
    chk("R12 sample keeps core", {pad_oe, pad_do}, {8'hA5, 8'h0F});
    run_ir(OPEX, irout);
    @(posedge tck); #9;
    chk("R12 extest drives latch", {pad_oe, pad_do}, {8'h5A, 8'hC3});

    run_ir(OPCL, irout);
    @(posedge tck); #9;
    chk("R8 clamp pins", {pad_oe, pad_do}, {8'h5A, 8'hC3});
    run_dr(4, 64'hB, d);
    chk("R8 clamp bypass path", d[3:0], 4'h6);

    run_ir(OPHZ, irout);
    set_in(8'hFF, 8'h11, 8'h3C, 8'h0F, 8'h33, 1);
    @(posedge tck); #9;
    chk("R9 highz oe", pad_oe, 8'h00);
    chk("R10 keepers in highz", {pad_pu, pad_bh}, {8'h0F, 8'h33});
    run_dr(6, 64'h2D, d);
    chk("R9 highz bypass path", d[5:0], 6'h1A);
    chk("R9 highz still off", pad_oe, 8'h00);

    pulse(2, 0);
    @(posedge tck); #9;
    chk("R1 tlr restores core", pad_oe, 8'hFF);
    run_dr(32, 0, d);
    chk("R1 tlr idcode", d[31:0], IDV);

    run_ir(OPHZ, irout);
    run_ir(OPB, irout);
    @(posedge tck); #9;
    chk("R9 released by new insn", pad_oe, 8'hFF);

    repeat (3) @(posedge tck);
    finish_run();
  end
endmodule